// File: doc/BRIEF.md
# Mixed-Sign Indexed Byte Dot-Product Accumulator

This block is a two-stage SIMD execution datapath. Each 32-bit lane of the first source vector holds four bytes. The lane multiplies those bytes, position by position, against the four bytes of one 32-bit element picked out of a 64-bit second source register. It adds the four products together and adds that sum to the lane's accumulator value. The same picked element feeds every lane.

One operand is read as signed bytes and the other as unsigned bytes. A single control bit chooses which operand is which.

A width select picks either a 64-bit operation (two lanes) or a 128-bit operation (four lanes, built from two consecutive 64-bit registers). In 128-bit mode an odd register number for the destination or the first source is illegal. The block flags that case, withholds the write-enable and passes the accumulator through unchanged.

Operations enter through a valid/ready handshake and leave through another one. Results appear two clock edges after acceptance. Backpressure on the output stalls the whole pipe.

Top module: `mixdot_unit`

## Requirements
- R1: For each active lane l, the result lane equals in_acc lane l plus the sum, over byte position k = 0..3, of byte k of in_src_a lane l times byte k of the selected element. Lane l occupies bits [32l+31:32l], and byte k of a lane or element occupies bits [8k+7:8k] within it.
- R2: With in_sign_sel = 1, in_src_a bytes are two's-complement signed and the element bytes are unsigned. With in_sign_sel = 0, in_src_a bytes are unsigned and the element bytes are signed.
- R3: in_idx = 0 selects in_src_b[31:0] as the element and in_idx = 1 selects in_src_b[63:32]. The same element is used by every lane.
- R4: With in_wide = 0 only lanes 0 and 1 are computed, and out_res[127:64] equals in_acc[127:64]. With in_wide = 1 all four lanes are computed.
- R5: When in_wide = 1 and bit 0 of in_dst_reg or of in_src_reg is 1, the result carries out_undef = 1 and out_we = 0, and out_res equals in_acc. Otherwise a valid result carries out_undef = 0 and out_we = 1.
- R6: Lane accumulation wraps modulo 2^32, with no saturation.
- R7: If an operation is accepted at a rising edge (in_valid and in_ready both high), out_valid rises with its result after the second rising edge counted from that acceptance edge. Nothing is visible after the first edge.
- R8: While out_valid = 1 and out_ready = 0, out_valid, out_res and out_undef hold their values and in_ready is 0. A result is consumed, and a new operation can be accepted, at the same edge when out_ready returns to 1.
- R9: After reset, out_valid = 0, out_we = 0 and in_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken |
| in_wide | input | 1 | 1: 128-bit (four lanes), 0: 64-bit (two lanes) |
| in_sign_sel | input | 1 | 1: first source signed, element unsigned; 0: the reverse |
| in_idx | input | 1 | Selects the element of in_src_b |
| in_dst_reg | input | 5 | Destination register number |
| in_src_reg | input | 5 | First-source register number |
| in_src_a | input | 128 | First source vector |
| in_src_b | input | 64 | Second source register |
| in_acc | input | 128 | Accumulator vector (current destination contents) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 128 | Accumulated result |
| out_we | output | 1 | Destination write-enable |
| out_undef | output | 1 | Illegal register numbering flag |

## Verification
The two functions that can fall in the same cycle are the release of a held result and the acceptance of a new operation. Both happen at the one edge where out_ready returns high after a stall.

The bench holds a result under backpressure, keeps a second operation waiting at the input, and releases both together. It then checks that the released result matches its arithmetic model and that the waiting operation emerges two edges later with its own correct value.

A long random stream with random out_ready mixes legal and illegal register numbers, so undefined and normal results cross the same stall-and-release edges. Every output is compared in order against a queue of independently computed values.

// File: rtl/mixdot_pkg.sv
package mixdot_pkg;
  localparam int BW  = 8;
  localparam int BPL = 4;
  localparam int LW  = BW * BPL;
  localparam int NL  = 4;
  localparam int VW  = NL * LW;
  localparam int EW  = BW + 1;
  localparam int PW  = 2 * EW;
  localparam int LPW = BPL * PW;

  typedef logic signed [EW-1:0] ext_t;
  typedef logic signed [PW-1:0] prod_t;

  // Extend a byte to a signed 9-bit value; unsigned bytes gain a zero bit.
  function automatic ext_t widen_byte(input logic [BW-1:0] v, input logic is_signed);
    return {is_signed & v[BW-1], v};
  endfunction

  // Full-precision product of two widened bytes.
  function automatic prod_t byte_mul(input logic [BW-1:0] a, input logic a_sgn,
                                     input logic [BW-1:0] b, input logic b_sgn);
    ext_t x;
    ext_t y;
    prod_t p;
    x = widen_byte(a, a_sgn);
    y = widen_byte(b, b_sgn);
    p = PW'(x) * PW'(y);
    return p;
  endfunction

  // Add four sign-extended products onto a lane accumulator, wrapping.
  function automatic logic [LW-1:0] lane_accum(input logic [LW-1:0] acc,
                                               input logic [LPW-1:0] prods);
    logic [LW-1:0] t;
    prod_t p;
    t = acc;
    for (int k = 0; k < BPL; k++) begin
      p = prods[k*PW +: PW];
      t = t + LW'(p);
    end
    return t;
  endfunction
endpackage

// File: rtl/mixdot_decode.sv
module mixdot_decode
  import mixdot_pkg::*;
#(
  parameter int RN_W = 5
) (
  input  logic            wide,
  input  logic            sign_sel,
  input  logic            idx,
  input  logic [RN_W-1:0] dst_reg,
  input  logic [RN_W-1:0] src_reg,
  input  logic [2*LW-1:0] src_b,
  output logic            undef,
  output logic            a_signed,
  output logic            b_signed,
  output logic [LW-1:0]   elem,
  output logic [NL-1:0]   lane_en
);
  localparam int HALF = NL / 2;

  logic unused_reg_hi;
  assign unused_reg_hi = ^{dst_reg[RN_W-1:1], src_reg[RN_W-1:1]};

  assign undef    = wide & (dst_reg[0] | src_reg[0]);
  assign a_signed = sign_sel;
  assign b_signed = ~sign_sel;
  assign elem     = idx ? src_b[2*LW-1:LW] : src_b[LW-1:0];

  for (genvar l = 0; l < NL; l++) begin : g_en
    if (l < HALF) begin : g_lo
      assign lane_en[l] = 1'b1;
    end else begin : g_hi
      assign lane_en[l] = wide;
    end
  end
endmodule

// File: rtl/mixdot_mul_stage.sv
module mixdot_mul_stage
  import mixdot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              in_valid,
  input  logic [VW-1:0]     src_a,
  input  logic [LW-1:0]     elem,
  input  logic              a_signed,
  input  logic              b_signed,
  input  logic [VW-1:0]     acc,
  input  logic [NL-1:0]     lane_en,
  input  logic              undef,
  output logic              s1_valid,
  output logic [NL*LPW-1:0] s1_prod,
  output logic [VW-1:0]     s1_acc,
  output logic [NL-1:0]     s1_lane_en,
  output logic              s1_undef
);
  logic [NL*LPW-1:0] prod_n;
  logic              load;

  assign load = adv & in_valid;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    for (genvar k = 0; k < BPL; k++) begin : g_byte
      assign prod_n[l*LPW + k*PW +: PW] =
        byte_mul(src_a[l*LW + k*BW +: BW], a_signed, elem[k*BW +: BW], b_signed);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_prod    <= '0;
      s1_acc     <= '0;
      s1_lane_en <= '0;
      s1_undef   <= 1'b0;
    end else if (load) begin
      s1_prod    <= prod_n;
      s1_acc     <= acc;
      s1_lane_en <= lane_en;
      s1_undef   <= undef;
    end
  end
endmodule

// File: rtl/mixdot_acc_stage.sv
module mixdot_acc_stage
  import mixdot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              s1_valid,
  input  logic [NL*LPW-1:0] s1_prod,
  input  logic [VW-1:0]     s1_acc,
  input  logic [NL-1:0]     s1_lane_en,
  input  logic              s1_undef,
  output logic              s2_valid,
  output logic [VW-1:0]     s2_res,
  output logic              s2_undef
);
  logic [VW-1:0] res_n;
  logic          load;

  assign load = adv & s1_valid;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] sum_l;
    assign sum_l = lane_accum(s1_acc[l*LW +: LW], s1_prod[l*LPW +: LPW]);
    assign res_n[l*LW +: LW] = (s1_undef || !s1_lane_en[l]) ? s1_acc[l*LW +: LW] : sum_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
    end else if (adv) begin
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_res   <= '0;
      s2_undef <= 1'b0;
    end else if (load) begin
      s2_res   <= res_n;
      s2_undef <= s1_undef;
    end
  end
endmodule

// File: rtl/mixdot_unit.sv
module mixdot_unit
  import mixdot_pkg::*;
#(
  parameter int RN_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_wide,
  input  logic            in_sign_sel,
  input  logic            in_idx,
  input  logic [RN_W-1:0] in_dst_reg,
  input  logic [RN_W-1:0] in_src_reg,
  input  logic [VW-1:0]   in_src_a,
  input  logic [2*LW-1:0] in_src_b,
  input  logic [VW-1:0]   in_acc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VW-1:0]   out_res,
  output logic            out_we,
  output logic            out_undef
);
  // Named internal events, visible to the bound checker.
  logic              pipe_adv;
  logic              s1_valid;
  logic              dec_undef;
  logic              dec_a_signed;
  logic              dec_b_signed;
  logic [LW-1:0]     dec_elem;
  logic [NL-1:0]     dec_lane_en;
  logic [NL*LPW-1:0] s1_prod;
  logic [VW-1:0]     s1_acc;
  logic [NL-1:0]     s1_lane_en;
  logic              s1_undef;

  assign pipe_adv = ~out_valid | out_ready;
  assign in_ready = pipe_adv;

  mixdot_decode #(.RN_W(RN_W)) u_dec (
    .wide     (in_wide),
    .sign_sel (in_sign_sel),
    .idx      (in_idx),
    .dst_reg  (in_dst_reg),
    .src_reg  (in_src_reg),
    .src_b    (in_src_b),
    .undef    (dec_undef),
    .a_signed (dec_a_signed),
    .b_signed (dec_b_signed),
    .elem     (dec_elem),
    .lane_en  (dec_lane_en)
  );

  mixdot_mul_stage u_mul (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (pipe_adv),
    .in_valid   (in_valid),
    .src_a      (in_src_a),
    .elem       (dec_elem),
    .a_signed   (dec_a_signed),
    .b_signed   (dec_b_signed),
    .acc        (in_acc),
    .lane_en    (dec_lane_en),
    .undef      (dec_undef),
    .s1_valid   (s1_valid),
    .s1_prod    (s1_prod),
    .s1_acc     (s1_acc),
    .s1_lane_en (s1_lane_en),
    .s1_undef   (s1_undef)
  );

  mixdot_acc_stage u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (pipe_adv),
    .s1_valid   (s1_valid),
    .s1_prod    (s1_prod),
    .s1_acc     (s1_acc),
    .s1_lane_en (s1_lane_en),
    .s1_undef   (s1_undef),
    .s2_valid   (out_valid),
    .s2_res     (out_res),
    .s2_undef   (out_undef)
  );

  assign out_we = out_valid & ~out_undef;
endmodule

// File: rtl/mixdot_chk.sv
module mixdot_chk
  import mixdot_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_res,
  input logic          out_we,
  input logic          out_undef,
  input logic          s1_valid,
  input logic          pipe_adv
);
  assert_accept_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_valid);

  assert_stage_to_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && pipe_adv) |=> out_valid);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_undef)));

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_undef_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_undef) |-> !out_we);

  assert_legal_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_undef) |-> out_we);

  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_we);
endmodule

bind mixdot_unit mixdot_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_res   (out_res),
  .out_we    (out_we),
  .out_undef (out_undef),
  .s1_valid  (s1_valid),
  .pipe_adv  (pipe_adv)
);

// File: tb/sim_mixdot_unit.sv
module sim_mixdot_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic         in_wide;
  logic         in_sign_sel;
  logic         in_idx;
  logic [4:0]   in_dst_reg;
  logic [4:0]   in_src_reg;
  logic [127:0] in_src_a;
  logic [63:0]  in_src_b;
  logic [127:0] in_acc;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_res;
  logic         out_we;
  logic         out_undef;

  mixdot_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_wide(in_wide), .in_sign_sel(in_sign_sel), .in_idx(in_idx),
    .in_dst_reg(in_dst_reg), .in_src_reg(in_src_reg), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_acc(in_acc), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_we(out_we), .out_undef(out_undef)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit accepted;
  bit rand_bp = 0;
  string cur_tag;

  typedef struct {
    logic [127:0] res;
    logic         undef;
    string        tag;
  } exp_t;
  exp_t q[$];

  // Arithmetic reference: integer products summed in a wide integer, then truncated.
  function automatic logic [127:0] model(bit w, bit s, bit ix, logic [4:0] d, logic [4:0] sr,
                                         logic [127:0] a, logic [63:0] b, logic [127:0] acc);
    logic [127:0] r;
    int base;
    int n;
    r = acc;
    if (w && (d[0] || sr[0])) return acc;
    base = ix ? 32 : 0;
    n = w ? 4 : 2;
    for (int l = 0; l < n; l++) begin
      longint sum;
      sum = longint'(acc[l*32 +: 32]);
      for (int k = 0; k < 4; k++) begin
        int av;
        int bv;
        av = int'(a[l*32 + k*8 +: 8]);
        bv = int'(b[base + k*8 +: 8]);
        if (s && av >= 128) av = av - 256;
        if (!s && bv >= 128) bv = bv - 256;
        sum = sum + longint'(av * bv);
      end
      r[l*32 +: 32] = sum[31:0];
    end
    return r;
  endfunction

  function automatic bit model_undef(bit w, logic [4:0] d, logic [4:0] sr);
    return w && (d[0] || sr[0]);
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Observe handshakes that the next rising edge will complete, then move to the next falling edge.
  task automatic step();
    #1;
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R7 unexpected result", out_res, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(out_res === e.res, {e.tag, " result"}, out_res, e.res);
        check(out_undef === e.undef && out_we === !e.undef, {e.tag, " R5 flags"},
              {126'd0, out_undef, out_we}, {126'd0, e.undef, !e.undef});
      end
    end
    if (in_valid && in_ready) begin
      exp_t e;
      e.res = model(in_wide, in_sign_sel, in_idx, in_dst_reg, in_src_reg, in_src_a, in_src_b, in_acc);
      e.undef = model_undef(in_wide, in_dst_reg, in_src_reg);
      e.tag = cur_tag;
      q.push_back(e);
      accepted = 1;
    end
    @(negedge clk);
    if (rand_bp) out_ready = ($urandom % 4) != 0;
  endtask

  task automatic load_op(bit w, bit s, bit ix, logic [4:0] d, logic [4:0] sr,
                         logic [127:0] a, logic [63:0] b, logic [127:0] acc);
    in_wide = w; in_sign_sel = s; in_idx = ix; in_dst_reg = d; in_src_reg = sr;
    in_src_a = a; in_src_b = b; in_acc = acc;
  endtask

  task automatic send(bit w, bit s, bit ix, logic [4:0] d, logic [4:0] sr,
                      logic [127:0] a, logic [63:0] b, logic [127:0] acc, string tag);
    load_op(w, s, ix, d, sr, a, b, acc);
    cur_tag = tag;
    in_valid = 1;
    accepted = 0;
    while (!accepted) step();
    in_valid = 0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (q.size() > 0 && guard < 100) begin
      step();
      guard++;
    end
    check(q.size() == 0, "R8 drain lost results", 128'(q.size()), '0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] ea;
    logic [127:0] ec;
    rst_n = 0; in_valid = 0; out_ready = 1;
    load_op(0, 0, 0, 5'd0, 5'd0, '0, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R9 reset state
    check(out_valid === 1'b0 && out_we === 1'b0 && in_ready === 1'b1, "R9 reset state",
          {125'd0, out_valid, out_we, in_ready}, 128'd1);
    @(negedge clk);

    // R7 latency, sampled directly
    load_op(1, 1, 1, 5'd2, 5'd4, {16{8'h93}}, 64'h01FF7F80_00000000, {4{32'h10}});
    ea = model(1, 1, 1, 5'd2, 5'd4, {16{8'h93}}, 64'h01FF7F80_00000000, {4{32'h10}});
    in_valid = 1;
    #1 check(in_ready === 1'b1, "R7 ready before accept", {127'd0, in_ready}, 128'd1);
    @(negedge clk);
    in_valid = 0;
    #1 check(out_valid === 1'b0, "R7 nothing after first edge", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    #1 check(out_valid === 1'b1 && out_res === ea, "R7 R1 result after second edge", out_res, ea);
    @(negedge clk);
    #1 check(out_valid === 1'b0, "R7 consumed", {127'd0, out_valid}, 128'd0);
    @(negedge clk);

    // R8 stall, then release and accept on the same edge
    out_ready = 0;
    load_op(0, 0, 0, 5'd3, 5'd7, {16{8'hC4}}, 64'h00000000_80FF017F, {4{32'hFFFFFF00}});
    ea = model(0, 0, 0, 5'd3, 5'd7, {16{8'hC4}}, 64'h00000000_80FF017F, {4{32'hFFFFFF00}});
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    repeat (2) @(negedge clk);
    load_op(1, 1, 0, 5'd6, 5'd8, {4{32'h80FF7F01}}, 64'h12345678_FF80FF80, {32'h7FFFFFFF, 32'h80000000, 32'h1, 32'h0});
    ec = model(1, 1, 0, 5'd6, 5'd8, {4{32'h80FF7F01}}, 64'h12345678_FF80FF80, {32'h7FFFFFFF, 32'h80000000, 32'h1, 32'h0});
    in_valid = 1;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(out_valid === 1'b1 && out_res === ea, "R8 held result", out_res, ea);
      check(in_ready === 1'b0, "R8 input blocked during stall", {127'd0, in_ready}, 128'd0);
      @(negedge clk);
    end
    out_ready = 1;
    #1 check(out_res === ea && in_ready === 1'b1, "R8 release with accept", out_res, ea);
    @(negedge clk);
    in_valid = 0;
    #1 check(out_valid === 1'b0, "R8 R7 queued op not yet out", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    #1 check(out_valid === 1'b1 && out_res === ec, "R8 R6 queued op result", out_res, ec);
    @(negedge clk);

    // Corner operands: most negative signed byte against largest unsigned byte, and wraps
    send(1, 1, 0, 5'd0, 5'd2, {16{8'h80}}, {32'h0, 32'hFFFFFFFF}, '0, "R2 corner 80xFF signed-a");
    send(1, 0, 1, 5'd0, 5'd2, {16{8'h80}}, {32'hFFFFFFFF, 32'h0}, '0, "R2 R3 corner 80xFF signed-b");
    send(1, 1, 0, 5'd4, 5'd6, {16{8'h7F}}, {32'h0, 32'hFFFFFFFF}, {4{32'h7FFFFFFF}}, "R6 positive wrap");
    send(1, 1, 1, 5'd4, 5'd6, {16{8'h80}}, {32'hFFFFFFFF, 32'h0}, {4{32'h80000000}}, "R6 negative wrap");
    send(0, 1, 0, 5'd1, 5'd3, {16{8'hFF}}, {32'h0, 32'hFFFFFFFF}, {32'hDEADBEEF, 32'hCAFEF00D, 32'h5, 32'h6}, "R4 narrow upper lanes kept");
    send(1, 0, 0, 5'd1, 5'd2, {16{8'h11}}, 64'h22222222_33333333, {4{32'hA5A5A5A5}}, "R5 odd destination");
    send(1, 0, 0, 5'd2, 5'd9, {16{8'h11}}, 64'h22222222_33333333, {4{32'h5A5A5A5A}}, "R5 odd source");
    send(0, 0, 0, 5'd9, 5'd11, {16{8'h11}}, 64'h22222222_33333333, {4{32'h0F0F0F0F}}, "R5 odd numbers legal when narrow");
    drain();

    // Near-exhaustive sweep: every first-source byte value against 64 element byte values, both signs
    for (int s = 0; s < 2; s++) begin
      for (int av = 0; av < 256; av++) begin
        for (int bi = 0; bi < 64; bi++) begin
          logic [7:0] a8;
          logic [7:0] b8;
          logic [31:0] lane;
          logic [31:0] el;
          logic [127:0] av128;
          a8 = 8'(av);
          b8 = 8'(bi * 37 + av);
          lane = {a8, ~a8, a8 ^ 8'h80, a8};
          el = {b8 + 8'd1, ~b8, b8 ^ 8'h80, b8};
          av128 = {lane, lane ^ 32'h0F0F0F0F, {a8, a8, a8, a8}, lane};
          send(bi[0], s[0], bi[1], 5'(bi[5:2] * 2), 5'(av[3:0] * 2), av128,
               bi[1] ? {el, ~el} : {~el, el},
               {$urandom, $urandom, $urandom, $urandom}, "R1 R2 R3 R4 sweep");
        end
      end
    end
    drain();

    // Random stream with random backpressure, legal and illegal register numbers mixed
    rand_bp = 1;
    for (int i = 0; i < 3000; i++) begin
      send($urandom % 2, $urandom % 2, $urandom % 2, 5'($urandom), 5'($urandom),
           {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, "R1 R5 R6 R8 random stream");
    end
    rand_bp = 0;
    out_ready = 1;
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule